// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the two sleep states of a small 8-bit controller core. Software asks for a light sleep (idle) or a deep sleep (power-down). The block then gates the processor clock, the peripheral clock and the oscillator to match the state it enters. While either state is active, it also overrides the external bus pins: the address latch strobe, the program fetch strobe, the low byte port and the high byte port. The override levels depend on a strap that says whether program memory is internal or external.

The block wakes the core in one of two ways. Idle ends on any enabled interrupt. Deep sleep ignores every source except an enabled external interrupt or the hardware reset pin. After an interrupt wakes the core from deep sleep, the processor clock stays gated for a stabilisation period while the oscillator restarts. When the reset pin ends idle, the core keeps running for a short window before its register reset takes over, and RAM writes are blocked for that whole window.

The internal clock ticks once every two input cycles, so the clock enables pulse on alternate cycles.

Top module: `lowpwr_ctrl`

## Requirements
- R1: In idle, cpuClkEn stays low, periphClkEn keeps pulsing and oscEn is high.
- R2: In idle, intPend high at a clock edge returns the block to run at that edge, and pinOvr drops.
- R3: In deep sleep, oscEn, cpuClkEn and periphClkEn are all low.
- R4: In deep sleep, intPend without extIntPend has no effect: pinOvr stays high and oscEn stays low.
- R5: While pinOvr is high, aleLvl and psenLvl are both 1 in idle and both 0 in deep sleep or stabilisation. In run, pinOvr is 0.
- R6: p0Float equals extProgMem while pinOvr is high, and is 0 otherwise.
- R7: p2Addr is 1 only in idle with extProgMem=1. In every other case p2Addr is 0, which means Port 2 keeps its latched data.
- R8: hwRst high in idle starts a window of WIN_CYCLES cycles. During the window cpuClkEn pulses, ramWrBlock=1 and sfrRst=0. After the window, sfrRst=1 for as long as hwRst stays high.
- R9: hwRst high in run or deep sleep gives sfrRst=1, ramWrBlock=1 and oscEn=1 from the next cycle on. The block returns to run one cycle after hwRst falls.
- R10: extIntPend high in deep sleep turns oscEn on at that edge. cpuClkEn is then held low for STAB_CYCLES cycles (default 1024) before the block returns to run.
- R11: idleReq and pdReq high together in run enter deep sleep.
- R12: In run, cpuClkEn and periphClkEn pulse in exactly one of every two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| hwRst | input | 1 | Hardware reset pin, synchronous, active high |
| idleReq | input | 1 | Software request to enter idle |
| pdReq | input | 1 | Software request to enter deep sleep |
| intPend | input | 1 | Any enabled interrupt is pending |
| extIntPend | input | 1 | An enabled external interrupt is pending |
| extProgMem | input | 1 | 1 = program memory is external |
| cpuClkEn | output | 1 | Processor clock enable (divided tick) |
| periphClkEn | output | 1 | Peripheral clock enable (divided tick) |
| oscEn | output | 1 | Oscillator run enable |
| pinOvr | output | 1 | Bus pin override is active |
| aleLvl | output | 1 | Forced level of the address latch strobe |
| psenLvl | output | 1 | Forced level of the program fetch strobe |
| p0Float | output | 1 | Port 0 is floated |
| p2Addr | output | 1 | Port 2 drives the address, not its latched data |
| ramWrBlock | output | 1 | Block internal RAM writes |
| sfrRst | output | 1 | Reset for the special function registers |

## Verification
The assertions assume that software raises idleReq or pdReq only while the core runs. They also assume that intPend is high whenever extIntPend is high, because an external interrupt is also an enabled interrupt. Both inputs are sampled only at clock edges. The bench drives every input a short time after a rising edge. It raises extIntPend only together with intPend, and it drops sleep requests once they have been taken. Within those limits, no property looks at how the inputs combine outside these contracts.

// File: rtl/lowpwr_pkg.sv
package lowpwr_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_PDOWN, ST_STAB, ST_RWIN, ST_RST
  } pmState_t;

  typedef struct packed {
    logic cntClr;   // restart the shared cycle counter
    logic oscOn;    // oscillator running, divide-by-two tick advances
    logic cpuGate;  // processor clock allowed
    logic perGate;  // peripheral clock allowed
  } pmStrobe_t;
endpackage

// File: rtl/lowpwr_datapath.sv
module lowpwr_datapath
  import lowpwr_pkg::*;
#(
  parameter int STAB_CYCLES = 1024,
  parameter int WIN_CYCLES  = 24
) (
  input  logic      clk,
  input  logic      rstN,
  input  pmStrobe_t strb,
  output logic      stabDone,
  output logic      winDone,
  output logic      cpuClkEn,
  output logic      periphClkEn
);
  localparam int MAXC  = (STAB_CYCLES > WIN_CYCLES) ? STAB_CYCLES : WIN_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [CNT_W-1:0] cnt;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (strb.cntClr)              cnt <= '0;
    else if (cnt != CNT_W'(MAXC - 1))  cnt <= cnt + 1'b1;
  end

  // divide-by-two stage: duty cycle of the input clock is irrelevant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tick <= 1'b0;
    else if (strb.oscOn)  tick <= ~tick;
  end

  assign stabDone    = (cnt == CNT_W'(STAB_CYCLES - 1));
  assign winDone     = (cnt == CNT_W'(WIN_CYCLES - 1));
  assign cpuClkEn    = tick & strb.cpuGate & strb.oscOn;
  assign periphClkEn = tick & strb.perGate & strb.oscOn;
endmodule

// File: rtl/lowpwr_ctrl_fsm.sv
module lowpwr_ctrl_fsm
  import lowpwr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      hwRst,
  input  logic      idleReq,
  input  logic      pdReq,
  input  logic      intPend,
  input  logic      extIntPend,
  input  logic      extProgMem,
  input  logic      stabDone,
  input  logic      winDone,
  output pmStrobe_t strb,
  output logic      oscEn,
  output logic      pinOvr,
  output logic      aleLvl,
  output logic      psenLvl,
  output logic      p0Float,
  output logic      p2Addr,
  output logic      ramWrBlock,
  output logic      sfrRst
);
  pmState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_RUN:   if (hwRst)           nextState = ST_RST;
                else if (pdReq)      nextState = ST_PDOWN;   // deep sleep wins
                else if (idleReq)    nextState = ST_IDLE;
      ST_IDLE:  if (hwRst)           nextState = ST_RWIN;
                else if (intPend)    nextState = ST_RUN;
      ST_PDOWN: if (hwRst)           nextState = ST_RST;
                else if (extIntPend) nextState = ST_STAB;
      ST_STAB:  if (hwRst)           nextState = ST_RST;
                else if (stabDone)   nextState = ST_RUN;
      ST_RWIN:  if (winDone)         nextState = ST_RST;
      ST_RST:   if (!hwRst)          nextState = ST_RUN;
      default:                       nextState = ST_RUN;
    endcase
  end

  logic inIdle, inDeep;
  assign inIdle = (state == ST_IDLE);
  assign inDeep = (state == ST_PDOWN) || (state == ST_STAB);

  always_comb begin
    strb.cntClr  = (state != nextState);
    strb.oscOn   = (state != ST_PDOWN);
    strb.cpuGate = (state == ST_RUN) || (state == ST_RWIN) || (state == ST_RST);
    strb.perGate = !inDeep;
  end

  assign oscEn      = strb.oscOn;
  assign pinOvr     = inIdle || inDeep;
  assign aleLvl     = inIdle;
  assign psenLvl    = inIdle;
  assign p0Float    = pinOvr && extProgMem;
  assign p2Addr     = inIdle && extProgMem;
  assign ramWrBlock = (state == ST_RWIN) || (state == ST_RST);
  assign sfrRst     = (state == ST_RST);
endmodule

// File: rtl/lowpwr_ctrl.sv
module lowpwr_ctrl
  import lowpwr_pkg::*;
#(
  parameter int STAB_CYCLES = 1024,
  parameter int WIN_CYCLES  = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic hwRst,
  input  logic idleReq,
  input  logic pdReq,
  input  logic intPend,
  input  logic extIntPend,
  input  logic extProgMem,
  output logic cpuClkEn,
  output logic periphClkEn,
  output logic oscEn,
  output logic pinOvr,
  output logic aleLvl,
  output logic psenLvl,
  output logic p0Float,
  output logic p2Addr,
  output logic ramWrBlock,
  output logic sfrRst
);
  pmStrobe_t strb;
  logic      stabDone, winDone;

  lowpwr_ctrl_fsm u_fsm (
    .clk(clk), .rstN(rstN), .hwRst(hwRst), .idleReq(idleReq), .pdReq(pdReq),
    .intPend(intPend), .extIntPend(extIntPend), .extProgMem(extProgMem),
    .stabDone(stabDone), .winDone(winDone), .strb(strb), .oscEn(oscEn),
    .pinOvr(pinOvr), .aleLvl(aleLvl), .psenLvl(psenLvl), .p0Float(p0Float),
    .p2Addr(p2Addr), .ramWrBlock(ramWrBlock), .sfrRst(sfrRst)
  );

  lowpwr_datapath #(.STAB_CYCLES(STAB_CYCLES), .WIN_CYCLES(WIN_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .stabDone(stabDone), .winDone(winDone),
    .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn)
  );
endmodule

// File: rtl/lowpwr_checks.sv
module lowpwr_checks (
  input logic clk,
  input logic rstN,
  input logic hwRst,
  input logic idleReq,
  input logic pdReq,
  input logic intPend,
  input logic extIntPend,
  input logic extProgMem,
  input logic cpuClkEn,
  input logic periphClkEn,
  input logic oscEn,
  input logic pinOvr,
  input logic aleLvl,
  input logic psenLvl,
  input logic p0Float,
  input logic p2Addr,
  input logic ramWrBlock,
  input logic sfrRst
);
  AST_IDLE_CPU_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && aleLvl) |-> (!cpuClkEn && oscEn)); // R1
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && aleLvl && intPend && !hwRst) |=> !pinOvr); // R2
  AST_DEEP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && !aleLvl) |-> (!cpuClkEn && !periphClkEn)); // R3
  AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && !aleLvl && !oscEn && !extIntPend && !hwRst) |=> (pinOvr && !oscEn)); // R4
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    pinOvr |-> (aleLvl == psenLvl)); // R5
  AST_PORT0_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    p0Float |-> (pinOvr && extProgMem)); // R6
  AST_PORT2_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    p2Addr |-> (pinOvr && aleLvl && extProgMem)); // R7
  AST_RESET_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && aleLvl && hwRst) |=> (ramWrBlock && !sfrRst && !pinOvr)); // R8
  AST_SFR_GUARDED: assert property (@(posedge clk) disable iff (!rstN)
    sfrRst |-> (ramWrBlock && oscEn)); // R9
  AST_STAB_START: assert property (@(posedge clk) disable iff (!rstN)
    (pinOvr && !aleLvl && !oscEn && extIntPend && !hwRst) |=> (oscEn && !cpuClkEn)); // R10
  AST_DEEP_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (!pinOvr && !ramWrBlock && !hwRst && idleReq && pdReq) |=> (pinOvr && !aleLvl)); // R11
  AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rstN)
    cpuClkEn |=> !cpuClkEn); // R12
endmodule

bind lowpwr_ctrl lowpwr_checks u_chk (.*);

// File: tb/sim_lowpwr_ctrl.sv
`timescale 1ns/1ps
module sim_lowpwr_ctrl;
  localparam int STAB = 1024;
  localparam int WIN  = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic hwRst = 0, idleReq = 0, pdReq = 0, intPend = 0, extIntPend = 0, extProgMem = 0;
  logic cpuClkEn, periphClkEn, oscEn, pinOvr, aleLvl, psenLvl, p0Float, p2Addr, ramWrBlock, sfrRst;

  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  lowpwr_ctrl #(.STAB_CYCLES(STAB), .WIN_CYCLES(WIN)) u0 (.*);

  // inputs: rst idle pd int ext mem | expects: ovr ale psen p0f p2a osc sfr ram
  localparam int NV = 13;
  localparam logic [13:0] VEC [NV] = '{
    14'b000000_00000100,  // run
    14'b010001_11111100,  // idle, external memory (R5 R6 R7)
    14'b000101_00000100,  // interrupt wakes idle (R2)
    14'b010000_11100100,  // idle, internal memory
    14'b000100_00000100,  // wake again (R2)
    14'b001001_10010000,  // deep sleep, external memory (R3 R5 R6)
    14'b000101_10010000,  // plain interrupt ignored (R4)
    14'b000000_10000000,  // internal memory, port 0 data (R6)
    14'b100000_00000111,  // reset pin in deep sleep (R9)
    14'b000000_00000100,  // back to run (R9)
    14'b011000_10000000,  // both requests, deep sleep wins (R11)
    14'b100000_00000111,  // reset pin (R9)
    14'b000000_00000100   // run
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // counts cpu / peripheral pulses over n cycles
  task automatic pulses(input int n, output int nc, output int np);
    nc = 0; np = 0;
    for (int i = 0; i < n; i++) begin
      step();
      nc += int'(cpuClkEn);
      np += int'(periphClkEn);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int nc, np;
    #25;
    check("reset R12 cpuClkEn", int'(cpuClkEn), 0);
    check("reset R5 pinOvr", int'(pinOvr), 0);
    check("reset R9 sfrRst", int'(sfrRst), 0);
    rstN = 1'b1;
    step();

    for (int v = 0; v < NV; v++) begin
      {hwRst, idleReq, pdReq, intPend, extIntPend, extProgMem} = VEC[v][13:8];
      step();
      check($sformatf("R5 row%0d pinOvr", v), int'(pinOvr), int'(VEC[v][7]));
      check($sformatf("R5 row%0d aleLvl", v), int'(aleLvl), int'(VEC[v][6]));
      check($sformatf("R5 row%0d psenLvl", v), int'(psenLvl), int'(VEC[v][5]));
      check($sformatf("R6 row%0d p0Float", v), int'(p0Float), int'(VEC[v][4]));
      check($sformatf("R7 row%0d p2Addr", v), int'(p2Addr), int'(VEC[v][3]));
      check($sformatf("R3 row%0d oscEn", v), int'(oscEn), int'(VEC[v][2]));
      check($sformatf("R9 row%0d sfrRst", v), int'(sfrRst), int'(VEC[v][1]));
      check($sformatf("R9 row%0d ramWrBlock", v), int'(ramWrBlock), int'(VEC[v][0]));
    end
    {hwRst, idleReq, pdReq, intPend, extIntPend, extProgMem} = '0;

    // R12: half-rate enables in run
    pulses(2, nc, np);
    check("R12 cpu pulses per two cycles", nc, 1);
    check("R12 periph pulses per two cycles", np, 1);
    pulses(6, nc, np);
    check("R12 cpu pulses per six cycles", nc, 3);

    // R1: idle keeps peripherals, stops cpu
    idleReq = 1; step(); idleReq = 0;
    pulses(4, nc, np);
    check("R1 idle cpu pulses", nc, 0);
    check("R1 idle periph pulses", np, 2);
    check("R1 idle oscEn", int'(oscEn), 1);

    // R2: external interrupt also wakes idle
    intPend = 1; extIntPend = 1; step(); intPend = 0; extIntPend = 0;
    check("R2 wake from idle pinOvr", int'(pinOvr), 0);

    // R3 and R10: deep sleep then stabilisation
    pdReq = 1; step(); pdReq = 0;
    pulses(4, nc, np);
    check("R3 deep cpu pulses", nc, 0);
    check("R3 deep periph pulses", np, 0);
    check("R3 deep oscEn", int'(oscEn), 0);
    intPend = 1; extIntPend = 1; step(); intPend = 0; extIntPend = 0;
    check("R10 oscEn on wake", int'(oscEn), 1);
    check("R10 cpu gated on wake", int'(cpuClkEn), 0);
    pulses(STAB - 1, nc, np);
    check("R10 cpu pulses during stabilisation", nc, 0);
    check("R10 override held in stabilisation", int'(pinOvr), 1);
    pulses(2, nc, np);
    check("R10 cpu resumes after stabilisation", nc, 1);
    check("R10 override released", int'(pinOvr), 0);

    // R8: reset pin during idle
    idleReq = 1; extProgMem = 1; step(); idleReq = 0;
    check("R7 idle p2Addr", int'(p2Addr), 1);
    hwRst = 1; step();
    check("R8 window ramWrBlock", int'(ramWrBlock), 1);
    check("R8 window sfrRst", int'(sfrRst), 0);
    check("R8 window pinOvr", int'(pinOvr), 0);
    nc = 0;
    for (int i = 0; i < WIN - 1; i++) begin
      step();
      nc += int'(cpuClkEn);
      if (sfrRst) check("R8 sfrRst early", 1, 0);
    end
    check("R8 cpu runs in window", int'(nc > 0), 1);
    step();
    check("R8 sfrRst after window", int'(sfrRst), 1);
    step();
    check("R8 sfrRst held", int'(sfrRst), 1);
    hwRst = 0; step();
    check("R9 release sfrRst", int'(sfrRst), 0);
    check("R9 release ramWrBlock", int'(ramWrBlock), 0);

    // R11 again with external memory: deep sleep, port 2 not address
    idleReq = 1; pdReq = 1; step(); idleReq = 0; pdReq = 0;
    check("R11 deep chosen oscEn", int'(oscEn), 0);
    check("R7 deep p2Addr", int'(p2Addr), 0);
    check("R6 deep p0Float", int'(p0Float), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule